// File: doc/BRIEF.md
# LIN Master Error Monitor

This block sits beside the bit engine of a LIN master node. It watches what the master transmits and what comes back on the receive pin, and it watches the received response. From these it raises six sticky error flags: bit error, physical bus error, timeout, framing error, checksum error and response preparation error. The UART shifter, the header generator and the checksum arithmetic sit outside the block. They feed it one-cycle strobes and levels.

For each error the block decides whether the transfer must be abandoned, and when. It reports that decision as a one-cycle cancel request with a 3-bit code that tells the bit engine where to stop. A bit error inside a data byte lets the byte run on to its stop bit. A bit error in a gap between bytes or data groups stops right after the bad bit, and so does a bit error during a wake-up. Bus faults, timeouts, framing faults and response preparation faults abort at once. Software clears the flags through a write-one-to-clear port. A one-cycle interrupt pulse marks every newly raised flag.

Top module: `lin_err_monitor`

## Requirements
- R1: When `smp_valid`, `tx_drive` and either `op_mode` or `wake_mode` are high, and `tx_bit` differs from `rx_bit`, flag bit 0 (bit error) is set on the next cycle.
- R2: A bit error sampled while `ph_data` is high gives no cancel at once. On the next cycle in which `smp_valid` and `ph_stop` are both high, the following cycle carries `cancel_req` with code 1. A bit error sampled on the stop bit itself gives code 1 on the next cycle.
- R3: A bit error sampled outside a data byte, stop bit or wake-up gives `cancel_req` with code 2 on the next cycle. Such regions include inter-byte spaces and the spaces between data groups.
- R4: A bit error sampled while `ph_wakeup` is high gives `cancel_req` with code 3 on the next cycle.
- R5: In operation or wake-up mode, a sample that reads the bus high during `ph_break`, low during `ph_delim` or high during `ph_wakeup` sets flag bit 1 (physical bus error) and gives cancel code 4.
- R6: `tmo_in` in operation mode sets flag bit 2 (timeout) and gives cancel code 4. Outside operation mode it has no effect.
- R7: `rx_stop_valid` with `rx_stop_bit` low in operation mode sets flag bit 3 (framing) and gives cancel code 4. Outside operation mode it has no effect.
- R8: `cks_valid` with `cks_ok` low in operation mode sets flag bit 4 (checksum) whatever `err_en` holds. It never requests a cancel.
- R9: In operation mode with `frame_sep` high, `rx_first_byte` while `resp_req` is low sets flag bit 5 (response preparation) and gives cancel code 4. It cannot be disabled, and it has no effect when `resp_req` is high or `frame_sep` is low.
- R10: `err_en` bits 0, 1, 2 and 3 enable the bit, physical bus, timeout and framing errors. A disabled error sets no flag and requests no cancel.
- R11: Flags reset to 0 and stay set until a cycle with `clr_we` high clears the bits marked in `clr_mask`. A flag that is raised in the same cycle as its clear stays set.
- R12: `irq` is high for one cycle together with the flag update whenever at least one flag goes from 0 to 1. A repeated error on a flag that is already set gives no pulse.
- R13: When several cancel causes meet in one cycle, the highest code wins (4 over 3 over 2 over 1). Any cancel drops a pending deferred cancel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Bit sample point strobe |
| tx_drive | input | 1 | Master is driving the bus for this bit |
| tx_bit | input | 1 | Level the master transmits |
| rx_bit | input | 1 | Level sampled on the receive pin |
| ph_break | input | 1 | Break field is being sent |
| ph_delim | input | 1 | Break delimiter is being sent |
| ph_wakeup | input | 1 | Wake-up pulse is being sent |
| ph_data | input | 1 | Start or data bit of a transmitted byte |
| ph_stop | input | 1 | Stop bit of a transmitted byte |
| op_mode | input | 1 | LIN operation mode |
| wake_mode | input | 1 | LIN wake-up mode |
| rx_stop_valid | input | 1 | Stop bit of a received response byte is sampled |
| rx_stop_bit | input | 1 | Value of that stop bit |
| cks_valid | input | 1 | Checksum comparison result is valid |
| cks_ok | input | 1 | Checksum comparison passed |
| frame_sep | input | 1 | Frame-separate mode |
| resp_req | input | 1 | Response request is set |
| rx_first_byte | input | 1 | First byte of a response or data group received |
| tmo_in | input | 1 | Timeout event from an external timer |
| err_en | input | 4 | Enables: bit, physical bus, timeout, framing |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 6 | Flags to clear (1 = clear) |
| err_flags | output | 6 | Sticky flags: bit, phys, timeout, framing, checksum, resp-prep |
| irq | output | 1 | One-cycle pulse on any newly set flag |
| cancel_req | output | 1 | One-cycle cancel request |
| cancel_kind | output | 3 | Cancel point: 1 after stop bit, 2 after bit in gap, 3 after bit in wake-up, 4 at once |

## Verification
The bound checker watches, on every cycle, that flags never drop without a clear and that each interrupt pulse goes with a flag that has just risen. It also checks that a disabled bit error never appears, that framing errors arise only in operation mode and always abort, and that the cancel code is non-zero exactly when a cancel is requested. The bench's scenarios cover what needs a history of stimulus. These are the deferral of a data-byte bit error to its stop bit, the choice among simultaneous cancel causes, and the cases that must leave no trace: a disabled timeout, framing outside operation mode, and a first byte that arrives after a response request. The scenarios also show a clear and a set of the same flag landing in one cycle.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;

    localparam int NUM_ERR = 6;
    localparam int NUM_EN  = 4;
    localparam int KIND_W  = 3;

    // Flag positions (software decodes these)
    localparam int E_BIT = 0;
    localparam int E_PHY = 1;
    localparam int E_TMO = 2;
    localparam int E_FRM = 3;
    localparam int E_CKS = 4;
    localparam int E_RPE = 5;

    typedef enum logic [KIND_W-1:0] {
        CK_NONE       = 3'd0,
        CK_AFTER_STOP = 3'd1,
        CK_AFTER_GAP  = 3'd2,
        CK_AFTER_WAKE = 3'd3,
        CK_ABORT      = 3'd4
    } cancel_kind_e;

    typedef struct packed {
        logic [NUM_ERR-1:0] hit;
        logic               abort;
        logic               wake;
        logic               gap;
        logic               stop_now;
        logic               defer;
    } det_t;

    function automatic cancel_kind_e pick_kind(det_t d, logic stop_done);
        if (d.abort)                   return CK_ABORT;
        else if (d.wake)               return CK_AFTER_WAKE;
        else if (d.gap)                return CK_AFTER_GAP;
        else if (d.stop_now || stop_done) return CK_AFTER_STOP;
        else                           return CK_NONE;
    endfunction

endpackage

// File: rtl/lin_err_detect.sv
module lin_err_detect
    import lin_err_pkg::*;
(
    input  logic              smp_valid,
    input  logic              tx_drive,
    input  logic              tx_bit,
    input  logic              rx_bit,
    input  logic              ph_break,
    input  logic              ph_delim,
    input  logic              ph_wakeup,
    input  logic              ph_data,
    input  logic              ph_stop,
    input  logic              op_mode,
    input  logic              wake_mode,
    input  logic              rx_stop_valid,
    input  logic              rx_stop_bit,
    input  logic              cks_valid,
    input  logic              cks_ok,
    input  logic              frame_sep,
    input  logic              resp_req,
    input  logic              rx_first_byte,
    input  logic              tmo_in,
    input  logic [NUM_EN-1:0] err_en,
    output det_t              det
);

    logic lin_on;
    logic bit_err;
    logic phy_err;
    logic tmo_err;
    logic frm_err;
    logic cks_err;
    logic rpe_err;

    always_comb begin
        lin_on  = op_mode | wake_mode;
        bit_err = smp_valid & tx_drive & lin_on & err_en[E_BIT] & (tx_bit ^ rx_bit);
        phy_err = smp_valid & lin_on & err_en[E_PHY] &
                  ((ph_break & rx_bit) | (ph_delim & ~rx_bit) | (ph_wakeup & rx_bit));
        tmo_err = tmo_in & op_mode & err_en[E_TMO];
        frm_err = rx_stop_valid & ~rx_stop_bit & op_mode & err_en[E_FRM];
        cks_err = cks_valid & ~cks_ok & op_mode;
        rpe_err = rx_first_byte & frame_sep & ~resp_req & op_mode;

        det            = '0;
        det.hit[E_BIT] = bit_err;
        det.hit[E_PHY] = phy_err;
        det.hit[E_TMO] = tmo_err;
        det.hit[E_FRM] = frm_err;
        det.hit[E_CKS] = cks_err;
        det.hit[E_RPE] = rpe_err;

        det.abort    = phy_err | tmo_err | frm_err | rpe_err;
        det.wake     = bit_err & ph_wakeup;
        det.defer    = bit_err & ~ph_wakeup & ph_data;
        det.stop_now = bit_err & ~ph_wakeup & ~ph_data & ph_stop;
        det.gap      = bit_err & ~ph_wakeup & ~ph_data & ~ph_stop;
    end

endmodule

// File: rtl/lin_cancel_ctl.sv
module lin_cancel_ctl
    import lin_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  det_t              det,
    input  logic              smp_valid,
    input  logic              ph_stop,
    output logic              cancel_req,
    output logic [KIND_W-1:0] cancel_kind
);

    logic         pend_q;
    logic         stop_done;
    cancel_kind_e kind_d;
    cancel_kind_e kind_q;

    always_comb begin
        stop_done = pend_q & smp_valid & ph_stop;
        kind_d    = pick_kind(det, stop_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            kind_q <= CK_NONE;
        end else begin
            kind_q <= kind_d;
            if (kind_d != CK_NONE)
                pend_q <= 1'b0;
            else if (det.defer)
                pend_q <= 1'b1;
        end
    end

    assign cancel_req  = (kind_q != CK_NONE);
    assign cancel_kind = kind_q;

endmodule

// File: rtl/lin_err_flags.sv
module lin_err_flags
    import lin_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_ERR-1:0] hit,
    input  logic               clr_we,
    input  logic [NUM_ERR-1:0] clr_mask,
    output logic [NUM_ERR-1:0] flags,
    output logic               irq
);

    logic [NUM_ERR-1:0] fresh;

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (hit[i])
                flags[i] <= 1'b1;
            else if (clr_we && clr_mask[i])
                flags[i] <= 1'b0;
        end
        assign fresh[i] = hit[i] & ~flags[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |fresh;
    end

endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
    import lin_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic               tx_drive,
    input  logic               tx_bit,
    input  logic               rx_bit,
    input  logic               ph_break,
    input  logic               ph_delim,
    input  logic               ph_wakeup,
    input  logic               ph_data,
    input  logic               ph_stop,
    input  logic               op_mode,
    input  logic               wake_mode,
    input  logic               rx_stop_valid,
    input  logic               rx_stop_bit,
    input  logic               cks_valid,
    input  logic               cks_ok,
    input  logic               frame_sep,
    input  logic               resp_req,
    input  logic               rx_first_byte,
    input  logic               tmo_in,
    input  logic [NUM_EN-1:0]  err_en,
    input  logic               clr_we,
    input  logic [NUM_ERR-1:0] clr_mask,
    output logic [NUM_ERR-1:0] err_flags,
    output logic               irq,
    output logic               cancel_req,
    output logic [KIND_W-1:0]  cancel_kind
);

    det_t det;

    lin_err_detect u_detect (
        .smp_valid     (smp_valid),
        .tx_drive      (tx_drive),
        .tx_bit        (tx_bit),
        .rx_bit        (rx_bit),
        .ph_break      (ph_break),
        .ph_delim      (ph_delim),
        .ph_wakeup     (ph_wakeup),
        .ph_data       (ph_data),
        .ph_stop       (ph_stop),
        .op_mode       (op_mode),
        .wake_mode     (wake_mode),
        .rx_stop_valid (rx_stop_valid),
        .rx_stop_bit   (rx_stop_bit),
        .cks_valid     (cks_valid),
        .cks_ok        (cks_ok),
        .frame_sep     (frame_sep),
        .resp_req      (resp_req),
        .rx_first_byte (rx_first_byte),
        .tmo_in        (tmo_in),
        .err_en        (err_en),
        .det           (det)
    );

    lin_cancel_ctl u_cancel (
        .clk         (clk),
        .rst         (rst),
        .det         (det),
        .smp_valid   (smp_valid),
        .ph_stop     (ph_stop),
        .cancel_req  (cancel_req),
        .cancel_kind (cancel_kind)
    );

    lin_err_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .hit      (det.hit),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .flags    (err_flags),
        .irq      (irq)
    );

endmodule

// File: rtl/lin_err_monitor_chk.sv
module lin_err_monitor_chk
    import lin_err_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               op_mode,
    input logic [NUM_EN-1:0]  err_en,
    input logic               clr_we,
    input logic [NUM_ERR-1:0] clr_mask,
    input logic [NUM_ERR-1:0] err_flags,
    input logic               irq,
    input logic               cancel_req,
    input logic [KIND_W-1:0]  cancel_kind
);

    // R11: a set flag only drops under a clear
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (($past(err_flags) & ~($past(clr_we) ? $past(clr_mask) : '0) & ~err_flags) == '0));

    // R12: every interrupt pulse accompanies a freshly risen flag
    p_irq_fresh_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((err_flags & ~$past(err_flags)) != '0));

    // R10: a disabled bit error never raises its flag
    p_bit_enable_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[E_BIT]) |-> $past(err_en[E_BIT]));

    // R7: framing error only in operation mode
    p_frm_mode_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[E_FRM]) |-> $past(op_mode));

    // R7: framing error aborts at once
    p_frm_abort_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[E_FRM]) |-> (cancel_req && cancel_kind == 3'd4));

    // R13: code is non-zero exactly when a cancel is requested
    p_kind_req_r13: assert property (@(posedge clk) disable iff (rst)
        cancel_req |-> (cancel_kind != 3'd0));

    p_kind_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !cancel_req |-> (cancel_kind == 3'd0));

endmodule

bind lin_err_monitor lin_err_monitor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_mode     (op_mode),
    .err_en      (err_en),
    .clr_we      (clr_we),
    .clr_mask    (clr_mask),
    .err_flags   (err_flags),
    .irq         (irq),
    .cancel_req  (cancel_req),
    .cancel_kind (cancel_kind)
);

// File: tb/lin_err_monitor_tb.sv
module lin_err_monitor_tb;

    typedef struct {
        logic smp, txd, tx, rx, brk, dlm, wak, dat, stp;
        logic op, wm, rsv, rsb, ckv, cko, fs, rq, fb, tmo, clr;
        logic [3:0] en;
        logic [5:0] cm;
    } stim_t;

    typedef struct {
        int         cyc;
        logic [5:0] fl;
        logic       irq;
        logic       cr;
        logic [2:0] ck;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 0, tx_drive = 0, tx_bit = 0, rx_bit = 0;
    logic ph_break = 0, ph_delim = 0, ph_wakeup = 0, ph_data = 0, ph_stop = 0;
    logic op_mode = 0, wake_mode = 0, rx_stop_valid = 0, rx_stop_bit = 0;
    logic cks_valid = 0, cks_ok = 0, frame_sep = 0, resp_req = 0;
    logic rx_first_byte = 0, tmo_in = 0, clr_we = 0;
    logic [3:0] err_en = '0;
    logic [5:0] clr_mask = '0;
    logic [5:0] err_flags;
    logic       irq, cancel_req;
    logic [2:0] cancel_kind;

    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    logic done = 1'b0;
    exp_t q[$];
    exp_t mon_e;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lin_err_monitor u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .tx_drive(tx_drive),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .ph_break(ph_break), .ph_delim(ph_delim),
        .ph_wakeup(ph_wakeup), .ph_data(ph_data), .ph_stop(ph_stop),
        .op_mode(op_mode), .wake_mode(wake_mode), .rx_stop_valid(rx_stop_valid),
        .rx_stop_bit(rx_stop_bit), .cks_valid(cks_valid), .cks_ok(cks_ok),
        .frame_sep(frame_sep), .resp_req(resp_req), .rx_first_byte(rx_first_byte),
        .tmo_in(tmo_in), .err_en(err_en), .clr_we(clr_we), .clr_mask(clr_mask),
        .err_flags(err_flags), .irq(irq), .cancel_req(cancel_req),
        .cancel_kind(cancel_kind)
    );

    // Monitor: pop expectations due this cycle and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc == cyc) begin
            mon_e = q.pop_front();
            n_vec++;
            if (err_flags !== mon_e.fl || irq !== mon_e.irq ||
                cancel_req !== mon_e.cr || cancel_kind !== mon_e.ck) begin
                n_bad++;
                $display("FAIL %s: flags=%b irq=%b cr=%b kind=%0d expected flags=%b irq=%b cr=%b kind=%0d",
                         mon_e.tag, err_flags, irq, cancel_req, cancel_kind,
                         mon_e.fl, mon_e.irq, mon_e.cr, mon_e.ck);
            end
        end
    end

    function automatic stim_t base();
        stim_t s;
        s = '{default: '0};
        s.op = 1'b1;
        s.en = 4'hF;
        return s;
    endfunction

    // Driver: apply one cycle of stimulus and push its expected result
    task automatic step(input stim_t s, input logic [5:0] fl, input logic ei,
                        input logic ecr, input logic [2:0] eck, input string tag);
        exp_t e;
        @(negedge clk);
        smp_valid = s.smp; tx_drive = s.txd; tx_bit = s.tx; rx_bit = s.rx;
        ph_break = s.brk; ph_delim = s.dlm; ph_wakeup = s.wak;
        ph_data = s.dat; ph_stop = s.stp; op_mode = s.op; wake_mode = s.wm;
        rx_stop_valid = s.rsv; rx_stop_bit = s.rsb; cks_valid = s.ckv;
        cks_ok = s.cko; frame_sep = s.fs; resp_req = s.rq;
        rx_first_byte = s.fb; tmo_in = s.tmo; err_en = s.en;
        clr_we = s.clr; clr_mask = s.cm;
        e.cyc = cyc + 1; e.fl = fl; e.irq = ei; e.cr = ecr; e.ck = eck; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic clear_all(input string tag);
        stim_t s;
        s = base(); s.clr = 1'b1; s.cm = 6'h3F;
        step(s, 6'h00, 1'b0, 1'b0, 3'd0, tag);
    endtask

    function automatic stim_t bit_smp(input logic tx, input logic rx);
        stim_t s;
        s = base(); s.smp = 1'b1; s.txd = 1'b1; s.tx = tx; s.rx = rx;
        return s;
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        step(base(), 6'h00, 0, 0, 3'd0, "R11 reset state");

        // R1 R3: bit error in an inter-byte gap
        step(bit_smp(1, 0), 6'h01, 1, 1, 3'd2, "R1 R3 gap bit error");
        clear_all("R11 clear");

        // R2: bit error inside a data byte waits for the stop bit
        s = bit_smp(0, 1); s.dat = 1;
        step(s, 6'h01, 1, 0, 3'd0, "R2 data error deferred");
        step(base(), 6'h01, 0, 0, 3'd0, "R2 still pending");
        s = bit_smp(1, 1); s.dat = 1;
        step(s, 6'h01, 0, 0, 3'd0, "R2 clean data bit");
        s = bit_smp(1, 1); s.stp = 1;
        step(s, 6'h01, 0, 1, 3'd1, "R2 cancel after stop");
        step(base(), 6'h01, 0, 0, 3'd0, "R2 single pulse");

        // R12: repeated error on a set flag gives no new pulse
        step(bit_smp(1, 0), 6'h01, 0, 1, 3'd2, "R12 no repeat irq");
        clear_all("R11 clear");

        // R4 R10: wake-up bit error with bus check disabled
        s = bit_smp(0, 1); s.op = 0; s.wm = 1; s.wak = 1; s.en = 4'b1101;
        step(s, 6'h01, 1, 1, 3'd3, "R4 R10 wake bit error");
        // R13 R5: same with bus check enabled, abort wins
        s.en = 4'hF;
        step(s, 6'h03, 1, 1, 3'd4, "R13 R5 abort wins");
        clear_all("R11 clear");

        // R10: disabled bit error ignored
        s = bit_smp(1, 0); s.en = 4'b1110;
        step(s, 6'h00, 0, 0, 3'd0, "R10 bit disabled");

        // R5: break high / delimiter low
        s = bit_smp(0, 1); s.brk = 1; s.en = 4'b1110;
        step(s, 6'h02, 1, 1, 3'd4, "R5 break high");
        clear_all("R11 clear");
        s = bit_smp(1, 0); s.dlm = 1; s.en = 4'b1110;
        step(s, 6'h02, 1, 1, 3'd4, "R5 delimiter low");
        clear_all("R11 clear");
        s = bit_smp(1, 1); s.dlm = 1;
        step(s, 6'h00, 0, 0, 3'd0, "R5 delimiter high ok");

        // R6 R10: timeout
        s = base(); s.tmo = 1; s.en = 4'b1011;
        step(s, 6'h00, 0, 0, 3'd0, "R10 timeout disabled");
        s.en = 4'hF;
        step(s, 6'h04, 1, 1, 3'd4, "R6 timeout");
        clear_all("R11 clear");
        s = base(); s.tmo = 1; s.op = 0; s.wm = 1;
        step(s, 6'h00, 0, 0, 3'd0, "R6 timeout outside op");

        // R7: framing
        s = base(); s.rsv = 1; s.rsb = 0;
        step(s, 6'h08, 1, 1, 3'd4, "R7 framing");
        clear_all("R11 clear");
        s.op = 0; s.wm = 1;
        step(s, 6'h00, 0, 0, 3'd0, "R7 framing outside op");

        // R8: checksum, enables off, no cancel
        s = base(); s.en = 4'h0; s.ckv = 1; s.cko = 0;
        step(s, 6'h10, 1, 0, 3'd0, "R8 checksum");
        step(s, 6'h10, 0, 0, 3'd0, "R12 checksum repeat");
        clear_all("R11 clear");

        // R9: response preparation
        s = base(); s.en = 4'h0; s.fs = 1; s.rq = 1; s.fb = 1;
        step(s, 6'h00, 0, 0, 3'd0, "R9 request present");
        s.rq = 0;
        step(s, 6'h20, 1, 1, 3'd4, "R9 early byte");
        s.fs = 0;
        step(s, 6'h20, 0, 0, 3'd0, "R9 not frame-separate");

        // R11: set wins over a simultaneous clear
        s = base(); s.ckv = 1; s.cko = 0; s.clr = 1; s.cm = 6'h3F;
        step(s, 6'h10, 1, 0, 3'd0, "R11 set beats clear");
        clear_all("R11 clear");

        // R2: bit error on the stop bit itself
        s = bit_smp(0, 1); s.stp = 1;
        step(s, 6'h01, 1, 1, 3'd1, "R2 error at stop");
        clear_all("R11 final clear");

        step(base(), 6'h00, 0, 0, 3'd0, "R11 idle");
        step(base(), 6'h00, 0, 0, 3'd0, "R11 idle");
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule